// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the byte-wide I/O slave of a four-channel DMA controller. A 4-bit port offset with read and write strobes selects one of sixteen ports. The lower eight ports give access to each channel's 16-bit address and count registers. Each of these ports is eight bits wide, so the block keeps a single shared byte pointer that decides whether an access reaches the low or the high byte. The upper eight ports hold the command, request, mask and mode registers, return status, and act as strobes that clear the pointer, clear the masks or reset the controller.

The arbiter and the address engine read the register contents from the block's outputs. The address engine writes the current address and count back through an update port and reports terminal counts as single-cycle events. Read data is combinational for the port being addressed in that cycle. Any side effect of the access, such as a pointer step or a flag clear, takes effect at the next clock edge.

Top module: `dma_reg_if`

## Requirements
- R1: Ports 0 to 7 are 16-bit register ports, with channel = offset bits 2:1 and count (1) or address (0) = offset bit 0. Every read or write of one of these ports uses the byte the pointer selects, low first. The access then flips the pointer. Accesses to ports 8 to 15 leave the pointer as it is.
- R2: A write to an address or count port loads the selected byte of the channel's base register and the same byte of its current register in the same cycle. No other access changes a base register.
- R3: A read of an address or count port returns the selected byte of that channel's current value, not its base value.
- R4: Any write to port 12 makes the next 16-bit access use the low byte.
- R5: A write to port 11 stores data bits 7:2 as the mode of the channel chosen by bits 1:0. On modeOut, channel n occupies bits 6n+5:6n, and within that field bit 0 is data bit 2.
- R6: A write to port 8 loads the command register, which appears on cmdOut.
- R7: A write to port 9 sets (data bit 2 = 1) or clears (bit 2 = 0) the software request bit of the channel in bits 1:0.
- R8: Port 10 sets or clears one mask bit, with the channel in bits 1:0 and the value in bit 2. Any write to port 14 clears all four masks. A write to port 15 loads all four masks from data bits 3:0.
- R9: A read of port 8 returns terminal-count flags in bits 3:0 and request-pending flags in bits 7:4, where pending is the software request OR hwReq. The read clears the flags after it. A tcEvent bit in the same cycle leaves its flag set.
- R10: Any write to port 13 sets all masks, clears the pointer, and clears the command register, the software requests and the terminal-count flags. Base values, current values and modes are kept.
- R11: When updValid is high, the current address and count of updChan take updAddr and updCount. If a CPU write hits the same register in the same cycle, the byte written by the CPU takes precedence.
- R12: After reset, every register is zero, all four masks are set and the pointer selects the low byte.
- R13: A read of ports 9 to 15 returns zero and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portAddr | input | 4 | Port offset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed port |
| updValid | input | 1 | Engine update of current values |
| updChan | input | 2 | Channel being updated |
| updAddr | input | 16 | New current address |
| updCount | input | 16 | New current count |
| tcEvent | input | 4 | Terminal-count event per channel |
| hwReq | input | 4 | Hardware request pending per channel |
| cmdOut | output | 8 | Command register |
| modeOut | output | 24 | Modes, 6 bits per channel |
| maskOut | output | 4 | Channel masks |
| swReqOut | output | 4 | Software request bits |
| baseAddrOut | output | 64 | Base addresses, 16 bits per channel |
| baseCountOut | output | 64 | Base counts, 16 bits per channel |
| curAddrOut | output | 64 | Current addresses |
| curCountOut | output | 64 | Current counts |

## Verification
The bench checks the byte pointer through mixed sequences: a read followed by a write, a clear in the middle of a pair, and a master clear. A design that steps the pointer only on writes, or does not reset it, would put bytes into the wrong half, and the following reads would show the swap. The bench also reads registers after the engine has moved the current value away from the base value, so a design that returns base values fails. A CPU byte write and an engine update are made to collide, which exposes a design that resolves the clash the wrong way. Terminal-count flags are read twice, once with a new event arriving during the read, so a design that drops that event or never clears the flags gives a wrong second status byte.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam int NCH = 4;
  localparam int CW  = $clog2(NCH);
  localparam int RW  = 16;
  localparam int BW  = 8;
  localparam int MW  = BW - 2;

  localparam logic [3:0] P_CMD     = 4'd8;
  localparam logic [3:0] P_REQ     = 4'd9;
  localparam logic [3:0] P_MASK1   = 4'd10;
  localparam logic [3:0] P_MODE    = 4'd11;
  localparam logic [3:0] P_CLRPTR  = 4'd12;
  localparam logic [3:0] P_MCLR    = 4'd13;
  localparam logic [3:0] P_CLRMASK = 4'd14;
  localparam logic [3:0] P_MASKALL = 4'd15;

  typedef enum logic [1:0] {RD_NONE, RD_ADDR, RD_COUNT, RD_STATUS} rdKind_t;

  typedef struct packed {
    logic          wrAddr;
    logic          wrCount;
    logic [CW-1:0] chan;
    logic          hiByte;
    logic          wrCmd;
    logic          wrReq;
    logic          wrMaskOne;
    logic          wrMode;
    logic          clrMask;
    logic          wrMaskAll;
    logic          masterClr;
    logic          rdStatus;
    rdKind_t       rdKind;
  } regStrobe_t;
endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dma_reg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] portAddr,
  input  logic       wrEn,
  input  logic       rdEn,
  output regStrobe_t strb
);
  logic ptrQ;
  logic is16;
  logic acc16;
  logic rdOnly;

  assign is16   = ~portAddr[3];
  assign acc16  = is16 & (wrEn | rdEn);
  assign rdOnly = rdEn & ~wrEn;

  always_comb begin
    strb.wrAddr    = wrEn & is16 & ~portAddr[0];
    strb.wrCount   = wrEn & is16 &  portAddr[0];
    strb.chan      = portAddr[CW:1];
    strb.hiByte    = ptrQ;
    strb.wrCmd     = wrEn & (portAddr == P_CMD);
    strb.wrReq     = wrEn & (portAddr == P_REQ);
    strb.wrMaskOne = wrEn & (portAddr == P_MASK1);
    strb.wrMode    = wrEn & (portAddr == P_MODE);
    strb.clrMask   = wrEn & (portAddr == P_CLRMASK);
    strb.wrMaskAll = wrEn & (portAddr == P_MASKALL);
    strb.masterClr = wrEn & (portAddr == P_MCLR);
    strb.rdStatus  = rdOnly & (portAddr == P_CMD);
    if (!rdOnly)      strb.rdKind = RD_NONE;
    else if (is16)    strb.rdKind = portAddr[0] ? RD_COUNT : RD_ADDR;
    else if (portAddr == P_CMD) strb.rdKind = RD_STATUS;
    else              strb.rdKind = RD_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ptrQ <= 1'b0;
    else if (wrEn && (portAddr == P_CLRPTR || portAddr == P_MCLR)) ptrQ <= 1'b0;
    else if (acc16) ptrQ <= ~ptrQ;
  end
endmodule

// File: rtl/dma_reg_data.sv
module dma_reg_data
  import dma_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [BW-1:0]     wrData,
  output logic [BW-1:0]     rdData,
  input  logic              updValid,
  input  logic [CW-1:0]     updChan,
  input  logic [RW-1:0]     updAddr,
  input  logic [RW-1:0]     updCount,
  input  logic [NCH-1:0]    tcEvent,
  input  logic [NCH-1:0]    hwReq,
  output logic [BW-1:0]     cmdOut,
  output logic [NCH*MW-1:0] modeOut,
  output logic [NCH-1:0]    maskOut,
  output logic [NCH-1:0]    swReqOut,
  output logic [NCH*RW-1:0] baseAddrOut,
  output logic [NCH*RW-1:0] baseCountOut,
  output logic [NCH*RW-1:0] curAddrOut,
  output logic [NCH*RW-1:0] curCountOut
);
  logic [BW-1:0]  cmdQ;
  logic [NCH-1:0] swReqQ, maskQ, tcQ;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic [RW-1:0] baseA, curA, baseC, curC;
    logic [MW-1:0] modeQ;
    logic hit;
    assign hit = (strb.chan == CW'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseA <= '0; curA <= '0; baseC <= '0; curC <= '0; modeQ <= '0;
      end else begin
        if (updValid && updChan == CW'(i)) begin
          curA <= updAddr;
          curC <= updCount;
        end
        if (strb.wrAddr && hit) begin
          if (strb.hiByte) begin baseA[RW-1:BW] <= wrData; curA[RW-1:BW] <= wrData; end
          else             begin baseA[BW-1:0]  <= wrData; curA[BW-1:0]  <= wrData; end
        end
        if (strb.wrCount && hit) begin
          if (strb.hiByte) begin baseC[RW-1:BW] <= wrData; curC[RW-1:BW] <= wrData; end
          else             begin baseC[BW-1:0]  <= wrData; curC[BW-1:0]  <= wrData; end
        end
        if (strb.wrMode && wrData[CW-1:0] == CW'(i)) modeQ <= wrData[BW-1:CW];
      end
    end

    assign baseAddrOut[i*RW +: RW]  = baseA;
    assign baseCountOut[i*RW +: RW] = baseC;
    assign curAddrOut[i*RW +: RW]   = curA;
    assign curCountOut[i*RW +: RW]  = curC;
    assign modeOut[i*MW +: MW]      = modeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ <= '0; swReqQ <= '0; maskQ <= '1; tcQ <= '0;
    end else if (strb.masterClr) begin
      cmdQ <= '0; swReqQ <= '0; maskQ <= '1; tcQ <= '0;
    end else begin
      if (strb.wrCmd) cmdQ <= wrData;
      if (strb.wrReq) swReqQ[wrData[CW-1:0]] <= wrData[CW];
      if (strb.clrMask) maskQ <= '0;
      else if (strb.wrMaskAll) maskQ <= wrData[NCH-1:0];
      else if (strb.wrMaskOne) maskQ[wrData[CW-1:0]] <= wrData[CW];
      tcQ <= (strb.rdStatus ? '0 : tcQ) | tcEvent;
    end
  end

  logic [RW-1:0] selWord;
  always_comb begin
    selWord = (strb.rdKind == RD_COUNT) ? curCountOut[strb.chan*RW +: RW]
                                        : curAddrOut[strb.chan*RW +: RW];
    case (strb.rdKind)
      RD_ADDR, RD_COUNT: rdData = strb.hiByte ? selWord[RW-1:BW] : selWord[BW-1:0];
      RD_STATUS:         rdData = {swReqQ | hwReq, tcQ};
      default:           rdData = '0;
    endcase
  end

  assign cmdOut   = cmdQ;
  assign maskOut  = maskQ;
  assign swReqOut = swReqQ;
endmodule

// File: rtl/dma_reg_if.sv
module dma_reg_if
  import dma_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        portAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BW-1:0]     wrData,
  output logic [BW-1:0]     rdData,
  input  logic              updValid,
  input  logic [CW-1:0]     updChan,
  input  logic [RW-1:0]     updAddr,
  input  logic [RW-1:0]     updCount,
  input  logic [NCH-1:0]    tcEvent,
  input  logic [NCH-1:0]    hwReq,
  output logic [BW-1:0]     cmdOut,
  output logic [NCH*MW-1:0] modeOut,
  output logic [NCH-1:0]    maskOut,
  output logic [NCH-1:0]    swReqOut,
  output logic [NCH*RW-1:0] baseAddrOut,
  output logic [NCH*RW-1:0] baseCountOut,
  output logic [NCH*RW-1:0] curAddrOut,
  output logic [NCH*RW-1:0] curCountOut
);
  regStrobe_t strb;

  dma_reg_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  dma_reg_data data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData),
    .updValid(updValid), .updChan(updChan), .updAddr(updAddr), .updCount(updCount),
    .tcEvent(tcEvent), .hwReq(hwReq), .cmdOut(cmdOut), .modeOut(modeOut),
    .maskOut(maskOut), .swReqOut(swReqOut), .baseAddrOut(baseAddrOut),
    .baseCountOut(baseCountOut), .curAddrOut(curAddrOut), .curCountOut(curCountOut)
  );
endmodule

// File: rtl/dma_reg_if_chk.sv
module dma_reg_if_chk
  import dma_reg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        portAddr,
  input logic              wrEn,
  input logic [BW-1:0]     wrData,
  input logic [BW-1:0]     cmdOut,
  input logic [NCH*MW-1:0] modeOut,
  input logic [NCH-1:0]    maskOut,
  input logic [NCH-1:0]    swReqOut,
  input logic [NCH*RW-1:0] baseAddrOut,
  input logic [NCH*RW-1:0] baseCountOut
);
  AST_CMD_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portAddr == P_CMD) |=> cmdOut == $past(wrData)); // R6

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portAddr == P_MODE) |=>
      modeOut[$past(wrData[CW-1:0])*MW +: MW] == $past(wrData[BW-1:CW])); // R5

  AST_REQ_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portAddr == P_REQ) |=> swReqOut[$past(wrData[CW-1:0])] == $past(wrData[CW])); // R7

  AST_MCLR_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portAddr == P_MCLR) |=> (maskOut == '1 && cmdOut == '0 && swReqOut == '0)); // R10

  AST_CLRMASK_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && portAddr == P_CLRMASK) |=> maskOut == '0); // R8

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && !portAddr[3]) |=> ($stable(baseAddrOut) && $stable(baseCountOut))); // R2
endmodule

bind dma_reg_if dma_reg_if_chk chk_i (
  .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrEn(wrEn), .wrData(wrData),
  .cmdOut(cmdOut), .modeOut(modeOut), .maskOut(maskOut), .swReqOut(swReqOut),
  .baseAddrOut(baseAddrOut), .baseCountOut(baseCountOut)
);

// File: tb/dma_reg_if_tb.sv
module dma_reg_if_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  portAddr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        updValid = 1'b0;
  logic [1:0]  updChan = '0;
  logic [15:0] updAddr = '0, updCount = '0;
  logic [3:0]  tcEvent = '0, hwReq = '0;
  logic [7:0]  cmdOut;
  logic [23:0] modeOut;
  logic [3:0]  maskOut, swReqOut;
  logic [63:0] baseAddrOut, baseCountOut, curAddrOut, curCountOut;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [15:0] mBaseA[4], mBaseC[4], mCurA[4], mCurC[4];
  logic [5:0]  mMode[4];
  logic [7:0]  mCmd;
  logic [3:0]  mReq, mMask, mTc;
  bit          mPtr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_reg_if dut_i (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .updValid(updValid), .updChan(updChan),
    .updAddr(updAddr), .updCount(updCount), .tcEvent(tcEvent), .hwReq(hwReq),
    .cmdOut(cmdOut), .modeOut(modeOut), .maskOut(maskOut), .swReqOut(swReqOut),
    .baseAddrOut(baseAddrOut), .baseCountOut(baseCountOut),
    .curAddrOut(curAddrOut), .curCountOut(curCountOut)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      mBaseA[i] = 0; mBaseC[i] = 0; mCurA[i] = 0; mCurC[i] = 0; mMode[i] = 0;
    end
    mCmd = 0; mReq = 0; mMask = 4'hF; mTc = 0; mPtr = 0;
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] a);
    logic [15:0] v;
    if (a < 8) begin
      v = a[0] ? mCurC[a[2:1]] : mCurA[a[2:1]];
      return mPtr ? v[15:8] : v[7:0];
    end
    if (a == 8) return {mReq | hwReq, mTc};
    return 8'h00;
  endfunction

  task automatic modelUpdate(input logic [3:0] a, input bit w, input bit r, input logic [7:0] d);
    int ch;
    if (updValid) begin mCurA[updChan] = updAddr; mCurC[updChan] = updCount; end
    if (w && a < 8) begin
      ch = a[2:1];
      if (a[0]) begin
        if (mPtr) begin mBaseC[ch][15:8] = d; mCurC[ch][15:8] = d; end
        else      begin mBaseC[ch][7:0]  = d; mCurC[ch][7:0]  = d; end
      end else begin
        if (mPtr) begin mBaseA[ch][15:8] = d; mCurA[ch][15:8] = d; end
        else      begin mBaseA[ch][7:0]  = d; mCurA[ch][7:0]  = d; end
      end
    end
    if (w && a == 13) begin
      mCmd = 0; mReq = 0; mMask = 4'hF; mTc = 0;
    end else begin
      if (r && !w && a == 8) mTc = 0;
      mTc = mTc | tcEvent;
      if (w && a == 8) mCmd = d;
      if (w && a == 9) mReq[d[1:0]] = d[2];
      if (w && a == 10) mMask[d[1:0]] = d[2];
      if (w && a == 14) mMask = 0;
      if (w && a == 15) mMask = d[3:0];
    end
    if (w && a == 11) mMode[d[1:0]] = d[7:2];
    if (w && (a == 12 || a == 13)) mPtr = 0;
    else if (a < 8 && (w || r)) mPtr = !mPtr;
  endtask

  task automatic compareAll();
    logic [63:0] fa, fc, ca, cc;
    logic [23:0] fm;
    for (int i = 0; i < 4; i++) begin
      fa[i*16 +: 16] = mBaseA[i]; fc[i*16 +: 16] = mBaseC[i];
      ca[i*16 +: 16] = mCurA[i];  cc[i*16 +: 16] = mCurC[i];
      fm[i*6 +: 6]   = mMode[i];
    end
    chk("R6", "cmdOut", 64'(cmdOut), 64'(mCmd));
    chk("R8", "maskOut", 64'(maskOut), 64'(mMask));
    chk("R7", "swReqOut", 64'(swReqOut), 64'(mReq));
    chk("R5", "modeOut", 64'(modeOut), 64'(fm));
    chk("R2", "baseAddrOut", baseAddrOut, fa);
    chk("R2", "baseCountOut", baseCountOut, fc);
    chk("R11", "curAddrOut", curAddrOut, ca);
    chk("R11", "curCountOut", curCountOut, cc);
  endtask

  // one bus cycle: drive after negedge, check read data, update model at the edge, compare
  task automatic step(input logic [3:0] a, input bit w, input bit r, input logic [7:0] d, input string tag);
    logic [7:0] e;
    portAddr = a; wrEn = w; rdEn = r; wrData = d;
    #1;
    e = expRead(a);
    if (r) chk(tag, $sformatf("rdData port %0d", a), 64'(rdData), 64'(e));
    @(posedge clk);
    modelUpdate(a, w, r, d);
    @(negedge clk);
    wrEn = 0; rdEn = 0; updValid = 0; tcEvent = 0;
    compareAll();
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    step(a, 1, 0, d, tag);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    step(a, 0, 1, 8'h00, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    // R12 reset state
    chk("R12", "mask after reset", 64'(maskOut), 64'hF);
    chk("R12", "cmd after reset", 64'(cmdOut), 64'h0);
    compareAll();

    // R1 R2 R3: low then high byte, current read back
    wr(4'd0, 8'h34, "R1"); wr(4'd0, 8'h12, "R1");
    chk("R2", "ch0 base addr", 64'(baseAddrOut[15:0]), 64'h1234);
    rd(4'd0, "R3"); rd(4'd0, "R3");
    wr(4'd5, 8'hCD, "R2"); wr(4'd5, 8'hAB, "R2");
    chk("R2", "ch2 cur count", 64'(curCountOut[47:32]), 64'hABCD);
    rd(4'd5, "R3"); rd(4'd5, "R3");

    // R1: a read flips the pointer, so the following write lands in the high byte
    rd(4'd6, "R1"); wr(4'd6, 8'h77, "R1");
    chk("R1", "ch3 base addr high", 64'(baseAddrOut[63:48]), 64'h7700);
    // R1: non-16-bit ports leave the pointer alone
    wr(4'd7, 8'h01, "R1"); wr(4'd8, 8'h00, "R1"); wr(4'd7, 8'h02, "R1");
    chk("R1", "ch3 count", 64'(baseCountOut[63:48]), 64'h0201);

    // R4: clear pointer in the middle of a pair
    wr(4'd2, 8'hAA, "R4"); wr(4'd12, 8'h00, "R4");
    wr(4'd2, 8'h55, "R4"); wr(4'd2, 8'h66, "R4");
    chk("R4", "ch1 base addr", 64'(baseAddrOut[31:16]), 64'h6655);

    // R5 modes on every channel
    wr(4'd11, 8'b01_1_1_10_00, "R5"); wr(4'd11, 8'b10_0_0_01_01, "R5");
    wr(4'd11, 8'b11_1_0_00_10, "R5"); wr(4'd11, 8'b00_0_1_10_11, "R5");
    chk("R5", "ch2 mode", 64'(modeOut[17:12]), 64'b11_1_0_00);

    // R6 command
    wr(4'd8, 8'hA5, "R6"); wr(4'd8, 8'h3C, "R6");

    // R7 request set/clear
    wr(4'd9, 8'h06, "R7"); wr(4'd9, 8'h05, "R7"); wr(4'd9, 8'h02, "R7");
    chk("R7", "swReq", 64'(swReqOut), 64'h2);

    // R8 masks
    wr(4'd14, 8'hFF, "R8"); chk("R8", "clear all", 64'(maskOut), 64'h0);
    wr(4'd10, 8'h07, "R8"); wr(4'd15, 8'h09, "R8"); wr(4'd10, 8'h00, "R8");
    chk("R8", "mask after single clear", 64'(maskOut), 64'h8);

    // R11 engine update, then read returns the new current, base untouched
    updValid = 1; updChan = 2'd0; updAddr = 16'h4321; updCount = 16'h0010;
    step(4'd9, 0, 1, 8'h00, "R13");
    chk("R2", "ch0 base after update", 64'(baseAddrOut[15:0]), 64'h1234);
    rd(4'd0, "R3"); rd(4'd0, "R3");
    // R11 collision: CPU low byte wins over engine update on ch1 address
    updValid = 1; updChan = 2'd1; updAddr = 16'hBEEF; updCount = 16'h5555;
    wr(4'd2, 8'h11, "R11");
    chk("R11", "ch1 cur addr collision", 64'(curAddrOut[31:16]), 64'hBE11);
    wr(4'd12, 8'h00, "R11");

    // R9 status: flags, pending, clear-on-read, event during read
    hwReq = 4'b0100;
    tcEvent = 4'b0011; rd(4'd13, "R13");
    tcEvent = 4'b1000; rd(4'd8, "R9");
    rd(4'd8, "R9");
    rd(4'd8, "R9");
    hwReq = 4'b0000;

    // R13 reads of upper ports
    for (int p = 9; p < 16; p++) rd(4'(p), "R13");

    // R10 master clear keeps base, current and mode
    wr(4'd9, 8'h04, "R10"); tcEvent = 4'b0001; wr(4'd0, 8'h99, "R10");
    wr(4'd13, 8'h00, "R10");
    chk("R10", "mask after master clear", 64'(maskOut), 64'hF);
    chk("R10", "ch0 base kept", 64'(baseAddrOut[15:0]), 64'h1299);
    rd(4'd8, "R10"); rd(4'd0, "R10"); rd(4'd0, "R10");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule